// File: doc/BRIEF.md
# I2C Master Command Queue Engine

This block is the command and data front end of an I2C master controller. Software pushes 11-bit command words into a transmit queue. Each word holds a data byte, a read/write selector, a request for a repeated start before the byte, and a request for a stop after it. The engine takes words from the head of the queue and drives a byte-level bus sequencer through a request/done handshake. It issues start conditions, the address byte, write bytes, read bytes and stop conditions. Bytes read from the target are placed in a separate receive queue, from which software pops them.

To read, software pushes dummy read commands; one received byte comes back for each. When the transmit queue runs dry before a stop has been requested, the engine keeps the bus and waits for more commands. A NACK from the target on the address or on a write byte aborts the transfer. The abort flushes the pending commands and ends with a stop. The block also reports a status word, both queue levels, two threshold indications and sticky error flags.

Top module: `iicq_engine`

## Requirements
- R1: Command word encoding is as follows. Bits 7:0 are write data, bit 8 selects read (1) or write (0), bit 9 requests a stop after the byte, and bit 10 requests a repeated start before the byte. From an idle bus, the engine issues START, then a WRITE of {target address, direction bit}, then the byte operation, then STOP if bit 9 is set. Sequencer op codes are START=0, WRITE=1, READ=2, STOP=3. Each op is held stable from request until done.
- R2: A read command issues a READ op. The received byte is pushed into the receive queue and appears on `rx_byte`, and `rx_pop` removes it. `seq_rd_nack` equals the command's stop bit, so the master NACKs the last byte.
- R3: If the transmit queue empties without a stop having been requested, the engine issues no stop. It keeps the bus with master-active set and resumes with the next pushed command without a new start, unless the direction changes.
- R4: While the bus is held, a command with bit 10 set, or one whose direction differs from the current transfer, first causes a repeated START and a new address byte.
- R5: Both queues hold 64 entries. A push into a full transmit queue is dropped and sets `tx_over`.
- R6: A byte received while the receive queue is full is dropped and sets `rx_over`.
- R7: A pop of an empty receive queue sets `rx_under` and leaves the level at zero.
- R8: The status word is laid out as follows. Bit 0 is activity (engine busy or commands pending). Bit 1 is transmit queue not full, bit 2 is transmit queue empty, bit 3 is receive queue not empty, bit 4 reads 0, and bit 5 is master active (engine not idle). After reset the word is 6'h06.
- R9: `tx_empty_irq` is high when the transmit level is at or below `tx_thresh`. `rx_full_irq` is high when the receive level exceeds `rx_thresh`, so a threshold of N-1 fires once N bytes are held.
- R10: `tx_level` and `rx_level` change in the cycle after each accepted push or pop.
- R11: A NACK on the address byte or on a write byte sets `xfer_abort`, empties the transmit queue and makes the next op a STOP, after which the engine is idle.
- R12: The error flags stay set until a `flag_clr` pulse. A new event in the same cycle as the clear wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tgt_addr | input | 7 | 7-bit target address |
| cmd_push | input | 1 | Push `cmd_word` into the transmit queue |
| cmd_word | input | 11 | Command word |
| rx_pop | input | 1 | Pop one byte from the receive queue |
| rx_byte | output | 8 | Head of the receive queue |
| tx_thresh | input | 7 | Transmit threshold |
| rx_thresh | input | 7 | Receive threshold |
| flag_clr | input | 1 | Clear all error flags |
| status | output | 6 | Status word |
| tx_level | output | 7 | Transmit queue level |
| rx_level | output | 7 | Receive queue level |
| tx_empty_irq | output | 1 | Transmit level at or below threshold |
| rx_full_irq | output | 1 | Receive level above threshold |
| tx_over | output | 1 | Transmit overflow flag |
| rx_over | output | 1 | Receive overflow flag |
| rx_under | output | 1 | Receive underflow flag |
| xfer_abort | output | 1 | Transfer abort flag |
| seq_req | output | 1 | Operation request to the bus sequencer |
| seq_op | output | 2 | Requested operation code |
| seq_wdata | output | 8 | Byte to send for a WRITE op |
| seq_rd_nack | output | 1 | Send NACK after a READ op |
| seq_done | input | 1 | Single-cycle completion of the requested op |
| seq_nack | input | 1 | Target NACKed a WRITE op, valid with `seq_done` |
| seq_rdata | input | 8 | Byte received on a READ op, valid with `seq_done` |

## Verification
The assertions rely on a few properties of the sequencer interface. `seq_done` is a single-cycle pulse that only ever answers a pending `seq_req`. `seq_nack` and `seq_rdata` are taken as meaningful only alongside that pulse. Software issues at most one push and one pop per cycle. The bench keeps within these limits with a sequencer model that answers a held request exactly one cycle after seeing it, can be stalled to let the transmit queue fill, and drives a NACK only on a chosen write op, so queue fill, overflow, abort and restart paths are all reached through legal handshakes.

// File: rtl/iicq_pkg.sv
`timescale 1ns/1ps
// Shared types for the I2C command queue engine.
// Assumes: command word fields sit at fixed bit positions that software relies on.
package iicq_pkg;
    localparam int CMD_W  = 11;
    localparam int BYTE_W = 8;

    // Command word: restart-before at bit 10, stop-after at bit 9, read at bit 8.
    typedef struct packed {
        logic              restart;
        logic              stop;
        logic              rd;
        logic [BYTE_W-1:0] data;
    } cmd_t;

    // Byte-level sequencer operations.
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } seq_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_DATA,
        ST_HOLD,
        ST_STOP
    } eng_state_e;
endpackage

// File: rtl/iicq_fifo.sv
`timescale 1ns/1ps
// Synchronous queue with level counter and flush.
// Assumes: a push into a full queue and a pop from an empty one are dropped;
// flush wins over push and pop in the same cycle.
module iicq_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    input  logic                         flush,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          wr_en, rd_en;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (level == LW'(DEPTH));
    assign empty = (level == '0);
    assign wr_en = push && !full && !flush;
    assign rd_en = pop && !empty && !flush;
    assign dout  = mem[rd_ptr];

    // Storage write, no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= din;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_en) wr_ptr <= ptr_next(wr_ptr);
            if (rd_en) rd_ptr <= ptr_next(rd_ptr);
            case ({wr_en, rd_en})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R10
    level_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop && !flush) |=> (level == $past(level) + 1'b1));
    // R10
    level_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push && !flush) |=> (level == $past(level) - 1'b1));
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (level == LW'(DEPTH)));
endmodule

// File: rtl/iicq_ctrl.sv
`timescale 1ns/1ps
// Command sequencing engine: turns queued command words into byte-level
// sequencer operations (start, address, data, stop).
// Assumes: seq_done is a one-cycle pulse answering a held seq_req; seq_nack is
// meaningful only with seq_done on a WRITE op; head is valid when tx_empty is low.
module iicq_ctrl
    import iicq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  cmd_t        head,
    input  logic        tx_empty,
    input  logic [6:0]  tgt_addr,
    input  logic        seq_done,
    input  logic        seq_nack,
    output logic        seq_req,
    output seq_op_e     seq_op,
    output logic [7:0]  seq_wdata,
    output logic        seq_rd_nack,
    output logic        tx_pop,
    output logic        rx_push,
    output logic        tx_flush,
    output logic        busy
);
    eng_state_e state_q, state_d;
    logic       dir_q;
    logic       nack_hit;

    // Operation presented to the sequencer for each state.
    always_comb begin
        seq_req     = 1'b0;
        seq_op      = OP_START;
        seq_wdata   = '0;
        seq_rd_nack = 1'b0;
        case (state_q)
            ST_START: seq_req = 1'b1;
            ST_ADDR: begin
                seq_req   = 1'b1;
                seq_op    = OP_WRITE;
                seq_wdata = {tgt_addr, dir_q};
            end
            ST_DATA: begin
                seq_req     = 1'b1;
                seq_op      = head.rd ? OP_READ : OP_WRITE;
                seq_wdata   = head.rd ? 8'h00 : head.data;
                seq_rd_nack = head.rd && head.stop;
            end
            ST_STOP: begin
                seq_req = 1'b1;
                seq_op  = OP_STOP;
            end
            default: ;
        endcase
    end

    // NACK on the address or on a write byte aborts the transfer.
    assign nack_hit = seq_done && seq_nack &&
                      ((state_q == ST_ADDR) || (state_q == ST_DATA && !head.rd));
    assign tx_flush = nack_hit;
    assign tx_pop   = (state_q == ST_DATA) && seq_done && !nack_hit;
    assign rx_push  = (state_q == ST_DATA) && seq_done && head.rd;
    assign busy     = (state_q != ST_IDLE);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (!tx_empty) state_d = ST_START;
            ST_START: if (seq_done)  state_d = ST_ADDR;
            ST_ADDR:  if (seq_done)  state_d = nack_hit ? ST_STOP : ST_DATA;
            ST_DATA:  if (seq_done)  state_d = (nack_hit || head.stop) ? ST_STOP : ST_HOLD;
            ST_HOLD: begin
                if (!tx_empty)
                    state_d = (head.restart || (head.rd != dir_q)) ? ST_START : ST_DATA;
            end
            ST_STOP:  if (seq_done)  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and direction latched at each (repeated) start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_START && state_q != ST_START) dir_q <= head.rd;
        end
    end

    // R1
    hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_req && !seq_done) |=> (seq_req && $stable(seq_op) && $stable(seq_wdata)));
    // R11
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> (seq_req && seq_op == OP_STOP));
endmodule

// File: rtl/iicq_engine.sv
`timescale 1ns/1ps
// Top of the I2C master command queue engine: transmit command queue,
// receive byte queue, sequencing engine, thresholds, status and error flags.
// Assumes: at most one push and one pop per cycle; flag set beats flag_clr.
module iicq_engine
    import iicq_pkg::*;
#(
    parameter int QDEPTH = 64,
    localparam int LW    = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        tgt_addr,
    input  logic              cmd_push,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              rx_pop,
    output logic [7:0]        rx_byte,
    input  logic [LW-1:0]     tx_thresh,
    input  logic [LW-1:0]     rx_thresh,
    input  logic              flag_clr,
    output logic [5:0]        status,
    output logic [LW-1:0]     tx_level,
    output logic [LW-1:0]     rx_level,
    output logic              tx_empty_irq,
    output logic              rx_full_irq,
    output logic              tx_over,
    output logic              rx_over,
    output logic              rx_under,
    output logic              xfer_abort,
    output logic              seq_req,
    output logic [1:0]        seq_op,
    output logic [7:0]        seq_wdata,
    output logic              seq_rd_nack,
    input  logic              seq_done,
    input  logic              seq_nack,
    input  logic [7:0]        seq_rdata
);
    logic [CMD_W-1:0] head_raw;
    cmd_t             head;
    seq_op_e          op_e;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_pop, tx_flush, rx_push, busy;

    assign head = cmd_t'(head_raw);

    iicq_fifo #(.W(CMD_W), .DEPTH(QDEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(cmd_word),
        .pop(tx_pop), .flush(tx_flush), .dout(head_raw), .level(tx_level),
        .full(tx_full), .empty(tx_empty)
    );

    iicq_fifo #(.W(8), .DEPTH(QDEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(seq_rdata),
        .pop(rx_pop), .flush(1'b0), .dout(rx_byte), .level(rx_level),
        .full(rx_full), .empty(rx_empty)
    );

    iicq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .head(head), .tx_empty(tx_empty),
        .tgt_addr(tgt_addr), .seq_done(seq_done), .seq_nack(seq_nack),
        .seq_req(seq_req), .seq_op(op_e), .seq_wdata(seq_wdata),
        .seq_rd_nack(seq_rd_nack), .tx_pop(tx_pop), .rx_push(rx_push),
        .tx_flush(tx_flush), .busy(busy)
    );

    assign seq_op       = op_e;
    assign tx_empty_irq = (tx_level <= tx_thresh);
    assign rx_full_irq  = (rx_level > rx_thresh);
    assign status       = {busy, 1'b0, !rx_empty, tx_empty, !tx_full, busy | !tx_empty};

    // Sticky error flags; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_over    <= 1'b0;
            rx_over    <= 1'b0;
            rx_under   <= 1'b0;
            xfer_abort <= 1'b0;
        end else begin
            tx_over    <= (tx_over    && !flag_clr) || (cmd_push && tx_full);
            rx_over    <= (rx_over    && !flag_clr) || (rx_push && rx_full);
            rx_under   <= (rx_under   && !flag_clr) || (rx_pop && rx_empty);
            xfer_abort <= (xfer_abort && !flag_clr) || tx_flush;
        end
    end

    // R5
    tx_over_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_over) |-> $past(cmd_push && tx_full));
    // R7
    rx_under_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_under) |-> $past(rx_pop && rx_empty));
    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_abort) |-> (tx_level == '0));
endmodule

// File: tb/sim_iicq_engine.sv
`timescale 1ns/1ps
// Bench for iicq_engine: sequencer model plus directed and sweeping checks.
module sim_iicq_engine;
    localparam int LW = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [6:0] tgt_addr = 7'h50;
    logic cmd_push = 1'b0;
    logic [10:0] cmd_word = '0;
    logic rx_pop = 1'b0;
    logic [7:0] rx_byte;
    logic [LW-1:0] tx_thresh = '0, rx_thresh = 7'd64;
    logic flag_clr = 1'b0;
    logic [5:0] status;
    logic [LW-1:0] tx_level, rx_level;
    logic tx_empty_irq, rx_full_irq, tx_over, rx_over, rx_under, xfer_abort;
    logic seq_req, seq_rd_nack;
    logic [1:0] seq_op;
    logic [7:0] seq_wdata;
    logic seq_done = 1'b0, seq_nack = 1'b0;
    logic [7:0] seq_rdata = '0;

    int tests = 0, fails = 0, cyc = 0;
    logic stall = 1'b0;
    int nack_at = -1, wr_idx = 0, rd_idx = 0, log_n = 0;
    logic [1:0] log_op [256];
    logic [7:0] log_wd [256];
    logic       log_rn [256];

    always #2 clk = ~clk;

    iicq_engine u0 (
        .clk(clk), .rst_n(rst_n), .tgt_addr(tgt_addr), .cmd_push(cmd_push),
        .cmd_word(cmd_word), .rx_pop(rx_pop), .rx_byte(rx_byte),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .flag_clr(flag_clr),
        .status(status), .tx_level(tx_level), .rx_level(rx_level),
        .tx_empty_irq(tx_empty_irq), .rx_full_irq(rx_full_irq),
        .tx_over(tx_over), .rx_over(rx_over), .rx_under(rx_under),
        .xfer_abort(xfer_abort), .seq_req(seq_req), .seq_op(seq_op),
        .seq_wdata(seq_wdata), .seq_rd_nack(seq_rd_nack), .seq_done(seq_done),
        .seq_nack(seq_nack), .seq_rdata(seq_rdata)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Sequencer model: answers a held request one cycle after seeing it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (seq_done) begin
                seq_done = 1'b0;
                seq_nack = 1'b0;
            end else if (rst_n && seq_req && !stall) begin
                log_op[log_n] = seq_op;
                log_wd[log_n] = seq_wdata;
                log_rn[log_n] = seq_rd_nack;
                log_n++;
                seq_nack = 1'b0;
                if (seq_op == 2'd1) begin
                    seq_nack = (wr_idx == nack_at);
                    wr_idx++;
                end else if (seq_op == 2'd2) begin
                    seq_rdata = pat(rd_idx);
                    rd_idx++;
                end
                seq_done = 1'b1;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic push_cmd(input logic rs, input logic st, input logic rd, input logic [7:0] d);
        @(negedge clk);
        cmd_word = {rs, st, rd, d};
        cmd_push = 1'b1;
        @(negedge clk);
        cmd_push = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (!(status[5] == 1'b0 && status[2] == 1'b1 && !seq_req) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk("engine reaches idle", int'(n < 3000), 1);
    endtask

    task automatic clear_log();
        log_n = 0;
        wr_idx = 0;
        rd_idx = 0;
    endtask

    task automatic exp_log(input string tag, input int i, input int op, input int wd);
        chk({tag, " op"}, int'(log_op[i]), op);
        if (op == 1) chk({tag, " byte"}, int'(log_wd[i]), wd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        chk("R8 status after reset", int'(status), 6'h06);
        chk("R10 tx level after reset", int'(tx_level), 0);
        chk("R10 rx level after reset", int'(rx_level), 0);
        chk("R12 flags after reset", int'({tx_over, rx_over, rx_under, xfer_abort}), 0);
        chk("R1 no request after reset", int'(seq_req), 0);

        // R1 single write with stop
        clear_log();
        push_cmd(0, 1, 0, 8'hA5);
        wait_idle();
        chk("R1 op count", log_n, 4);
        exp_log("R1 start", 0, 0, 0);
        exp_log("R1 addr", 1, 1, 8'hA0);
        exp_log("R1 data", 2, 1, 8'hA5);
        exp_log("R1 stop", 3, 3, 0);
        chk("R8 status idle", int'(status), 6'h06);

        // R3 hold without stop, then R4 direction change
        clear_log();
        push_cmd(0, 0, 0, 8'h11);
        repeat (20) @(negedge clk);
        chk("R3 held bus status", int'(status), 6'h27);
        chk("R3 no stop issued", log_n, 3);
        push_cmd(0, 0, 0, 8'h22);
        repeat (20) @(negedge clk);
        chk("R3 continue without start", log_n, 4);
        exp_log("R3 second byte", 3, 1, 8'h22);
        push_cmd(0, 1, 1, 8'h00);
        wait_idle();
        chk("R4 op count", log_n, 8);
        exp_log("R4 restart", 4, 0, 0);
        exp_log("R4 read addr", 5, 1, 8'hA1);
        exp_log("R2 read op", 6, 2, 0);
        chk("R2 rd nack on stop", int'(log_rn[6]), 1);
        exp_log("R4 stop", 7, 3, 0);
        chk("R2 rx level", int'(rx_level), 1);
        chk("R8 rx not empty bit", int'(status[3]), 1);
        chk("R2 rx byte", int'(rx_byte), int'(pat(0)));
        @(negedge clk);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        chk("R10 rx level after pop", int'(rx_level), 0);

        // R4 explicit restart, same direction
        clear_log();
        push_cmd(0, 0, 0, 8'h33);
        repeat (20) @(negedge clk);
        push_cmd(1, 1, 0, 8'h44);
        wait_idle();
        chk("R4 restart op count", log_n, 7);
        exp_log("R4 restart start", 3, 0, 0);
        exp_log("R4 restart addr", 4, 1, 8'hA0);
        exp_log("R4 restart data", 5, 1, 8'h44);

        // R11 NACK on address
        clear_log();
        nack_at = 0;
        push_cmd(0, 0, 0, 8'h10);
        push_cmd(0, 1, 0, 8'h20);
        wait_idle();
        chk("R11 addr nack op count", log_n, 3);
        exp_log("R11 addr nack stop", 2, 3, 0);
        chk("R11 abort flag", int'(xfer_abort), 1);
        chk("R11 tx flushed", int'(tx_level), 0);
        repeat (5) @(negedge clk);
        chk("R12 abort sticky", int'(xfer_abort), 1);
        pulse_clr();
        chk("R12 abort cleared", int'(xfer_abort), 0);

        // R11 NACK on data byte
        clear_log();
        nack_at = 1;
        push_cmd(0, 0, 0, 8'h10);
        push_cmd(0, 1, 0, 8'h20);
        wait_idle();
        chk("R11 data nack op count", log_n, 4);
        exp_log("R11 data nack byte", 2, 1, 8'h10);
        exp_log("R11 data nack stop", 3, 3, 0);
        chk("R11 abort flag data", int'(xfer_abort), 1);
        chk("R11 tx flushed data", int'(tx_level), 0);
        pulse_clr();
        nack_at = -1;

        // R5 R9 R10 transmit queue fill sweep with a stalled sequencer
        clear_log();
        stall = 1'b1;
        for (int t = 0; t <= 64; t++) begin
            tx_thresh = 7'(t);
            #0.1;
            chk("R9 tx irq at level 0", int'(tx_empty_irq), 1);
        end
        for (int k = 1; k <= 64; k++) begin
            push_cmd(0, k == 64, 0, 8'(k));
            chk("R10 tx level after push", int'(tx_level), k);
            chk("R5 not-full bit", int'(status[1]), int'(k < 64));
            chk("R8 tx empty bit", int'(status[2]), 0);
            for (int t = 0; t <= 64; t++) begin
                tx_thresh = 7'(t);
                #0.1;
                chk("R9 tx irq sweep", int'(tx_empty_irq), int'(k <= t));
            end
        end
        tx_thresh = '0;
        push_cmd(0, 0, 0, 8'hEE);
        chk("R5 overflow flag", int'(tx_over), 1);
        chk("R5 level stays full", int'(tx_level), 64);
        stall = 1'b0;
        wait_idle();
        chk("R5 queued op count", log_n, 67);
        exp_log("R5 addr", 1, 1, 8'hA0);
        for (int k = 1; k <= 64; k++) exp_log("R5 queued byte", k + 1, 1, k);
        exp_log("R5 final stop", 66, 3, 0);
        chk("R12 tx over sticky", int'(tx_over), 1);
        pulse_clr();
        chk("R12 tx over cleared", int'(tx_over), 0);

        // R2 R6 R7 R9 receive queue sweep
        clear_log();
        rx_thresh = 7'd64;
        for (int k = 0; k < 64; k++) push_cmd(0, 0, 1, 8'h00);
        begin
            int n = 0;
            while (rx_level != 7'd64 && n < 2000) begin
                @(negedge clk);
                n++;
            end
        end
        repeat (4) @(negedge clk);
        chk("R6 rx level full", int'(rx_level), 64);
        chk("R3 read hold, no stop", log_n, 66);
        chk("R3 master active while held", int'(status[5]), 1);
        chk("R2 rd ack on non-stop read", int'(log_rn[10]), 0);
        for (int t = 0; t <= 64; t++) begin
            rx_thresh = 7'(t);
            #0.1;
            chk("R9 rx irq sweep full", int'(rx_full_irq), int'(64 > t));
        end
        push_cmd(0, 1, 1, 8'h00);
        wait_idle();
        chk("R6 rx overflow flag", int'(rx_over), 1);
        chk("R6 rx level unchanged", int'(rx_level), 64);
        chk("R6 op count", log_n, 68);
        chk("R2 nack on last read", int'(log_rn[66]), 1);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            chk("R2 rx byte order", int'(rx_byte), int'(pat(i)));
            rx_thresh = 7'(63 - i);
            #0.1;
            chk("R9 rx irq at N-1", int'(rx_full_irq), 1);
            rx_thresh = 7'(64 - i);
            #0.1;
            chk("R9 rx irq at N", int'(rx_full_irq), 0);
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
            chk("R10 rx level after pop", int'(rx_level), 63 - i);
        end
        chk("R8 rx empty bit", int'(status[3]), 0);
        chk("R7 no underflow yet", int'(rx_under), 0);
        @(negedge clk);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        chk("R7 underflow flag", int'(rx_under), 1);
        chk("R7 level stays zero", int'(rx_level), 0);
        pulse_clr();
        chk("R12 all flags cleared", int'({tx_over, rx_over, rx_under, xfer_abort}), 0);

        summary();
        $finish;
    end
endmodule